// File: doc/BRIEF.md
# Adaptive Cache Warm-Up Completion Detector

This block watches a cache while a simulation model runs it functionally ahead of a measured sample, and decides when the cache state is trustworthy enough to end that functional phase. It takes a strobe for each retired instruction, a flag for each access that hit an unknown-state (cold-start) line, and the number of lines still in that unknown state. The retired-instruction stream is cut into intervals of fixed length. The number of cold-start accesses in each interval is stored in a circular history of the last N intervals. A running sum of that history is kept, so the average is compared with a threshold T by testing the sum against N×T, with no divider.

Warm-up ends at the close of an interval when at least N intervals have completed and the windowed sum is strictly below N×T. It also ends at once, mid-interval, when no cold lines remain. A short pipeline warm-up follows, then a measured run. Cold-start accesses seen in those two phases are summed into a saturating total that stays readable afterwards, as a gauge of how much the sample was disturbed by unknown state. A begin command restarts everything.

States, with their phase encoding: FUNC (00, functional warm-up), PIPE (01, pipeline warm-up), MEAS (10, measured run), DONE (11, finished). Transitions: FUNC to PIPE on a window pass or on zero cold lines; PIPE to MEAS after PIPE_LEN retirements; MEAS to DONE after MEAS_LEN retirements; DONE holds; begin sends any state to FUNC.

Top module: `wu_detector`

## Requirements
- R1: After reset the phase is 00, warm is 0, the measurement total is 0 and the history is empty.
- R2: An interval closes on its INTERVAL_LEN-th retirement; its count includes every cold-start flag seen in FUNC since the previous close, including one in the same cycle as the closing retirement.
- R3: The window test cannot end warm-up before HIST_N intervals have closed since the last reset or begin.
- R4: When the window test is allowed, FUNC moves to PIPE (phase 01) two clock edges after the closing retirement if the sum of the last HIST_N interval counts is strictly less than HIST_N×THRESH_T; a sum equal to that limit keeps phase 00.
- R5: The window holds only the most recent HIST_N interval counts; the oldest count leaves the sum when a new one enters.
- R6: In FUNC, a cold-line count of zero moves the phase to 01 at the next clock edge, whatever the interval position.
- R7: PIPE lasts exactly PIPE_LEN retirements, then the phase becomes 10 at the edge of the last one.
- R8: MEAS lasts exactly MEAS_LEN retirements, then the phase becomes 11 and stays 11 under any retirements or cold-start flags until begin.
- R9: The measurement total counts cold-start flags only in phases 01 and 10, saturates at its all-ones value, and is unchanged by flags in phases 00 and 11.
- R10: Begin in any phase returns the phase to 00 at the next edge, clears the measurement total, the interval count and the history.
- R11: The warm output is 1 exactly when the phase is not 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_i | input | 1 | Restart functional warm-up, clearing all history and totals |
| retire_i | input | 1 | One instruction retired this cycle |
| cold_acc_i | input | 1 | A cache access this cycle was a cold-start access |
| cold_lines_i | input | LINE_W | Number of lines still in the cold-start state |
| phase_o | output | 2 | Phase: 00 FUNC, 01 PIPE, 10 MEAS, 11 DONE |
| warm_o | output | 1 | Functional warm-up has ended |
| meas_cold_o | output | MEAS_W | Saturating cold-start count over pipeline warm-up and measurement |

## Verification
The bench aims at the window boundaries: a run of all-zero intervals must not pass before the HIST_N-th interval, which a design that tests an unfilled window would end too early; a sum exactly equal to HIST_N×THRESH_T must keep warm-up running, where an off-by-one comparator would pass it; and a window whose old heavy counts age out must pass only once they have left, which a design that never subtracts the departing count would never do. It also counts PIPE and MEAS retirements to the exact edge, drives cold-start flags in FUNC and DONE to catch a total that counts outside its phases, pushes the total past its width to catch wrap-around, and issues begin from a passed window to catch a history that is not cleared.

// File: rtl/wu_pkg.sv
package wu_pkg;

    typedef enum logic [1:0] {
        PH_FUNC = 2'b00,
        PH_PIPE = 2'b01,
        PH_MEAS = 2'b10,
        PH_DONE = 2'b11
    } wu_phase_e;

endpackage

// File: rtl/wu_interval_ctr.sv
module wu_interval_ctr #(
    parameter int unsigned INTERVAL_LEN = 10000,
    parameter int unsigned ACC_W        = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             active_i,
    input  logic             retire_i,
    input  logic             cold_i,
    output logic             done_o,
    output logic [ACC_W-1:0] count_o
);
    localparam int unsigned IW = (INTERVAL_LEN > 2) ? $clog2(INTERVAL_LEN) : 1;

    logic [IW-1:0]    instr_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_nx;
    logic             last;
    logic             done_q;
    logic [ACC_W-1:0] count_q;

    always_comb begin
        acc_nx = acc_q;
        if (cold_i && (acc_q != {ACC_W{1'b1}})) begin
            acc_nx = acc_q + 1'b1;
        end
        last = retire_i && (instr_q == IW'(INTERVAL_LEN - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            instr_q <= '0;
            acc_q   <= '0;
            done_q  <= 1'b0;
            count_q <= '0;
        end else begin
            done_q <= active_i && last;
            if (active_i) begin
                if (retire_i) begin
                    instr_q <= last ? '0 : instr_q + 1'b1;
                end
                if (last) begin
                    count_q <= acc_nx;
                    acc_q   <= '0;
                end else begin
                    acc_q <= acc_nx;
                end
            end
        end
    end

    assign done_o  = done_q;
    assign count_o = count_q;

    // R2: an interval spans at least two retirements, so its close is a lone pulse
    p_close_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R2: the position within the interval never reaches the interval length
    p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(instr_q) < INTERVAL_LEN);

endmodule

// File: rtl/wu_window.sv
module wu_window #(
    parameter int unsigned HIST_N   = 20,
    parameter int unsigned THRESH_T = 10,
    parameter int unsigned ACC_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic [ACC_W-1:0] val_i,
    output logic             fire_o
);
    localparam int unsigned PW    = (HIST_N > 2) ? $clog2(HIST_N) : 1;
    localparam int unsigned FW    = $clog2(HIST_N + 1);
    localparam int unsigned SUM_W = ACC_W + FW;
    localparam int unsigned LIMIT = HIST_N * THRESH_T;

    logic [ACC_W-1:0] hist_q [HIST_N];
    logic [PW-1:0]    wp_q;
    logic [FW-1:0]    fill_q;
    logic [SUM_W-1:0] sum_q;
    logic [SUM_W-1:0] sum_nx;
    logic             filled_nx;

    for (genvar g = 0; g < HIST_N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                hist_q[g] <= '0;
            end else if (push_i && (wp_q == PW'(g))) begin
                hist_q[g] <= val_i;
            end
        end
    end

    always_comb begin
        sum_nx    = sum_q + SUM_W'(val_i) - SUM_W'(hist_q[wp_q]);
        filled_nx = (fill_q >= FW'(HIST_N - 1));
        fire_o    = push_i && filled_nx && (32'(sum_nx) < LIMIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wp_q   <= '0;
            fill_q <= '0;
            sum_q  <= '0;
        end else if (push_i) begin
            wp_q  <= (wp_q == PW'(HIST_N - 1)) ? '0 : wp_q + 1'b1;
            sum_q <= sum_nx;
            if (fill_q != FW'(HIST_N)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // R10: a clear empties the window
    p_clear_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sum_q == '0) && (fill_q == '0));

    // R3: the filled-interval tally never exceeds the window depth
    p_fill_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fill_q) <= HIST_N);

    // R5: with nothing pushed the window sum holds
    p_sum_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !clr_i) |=> $stable(sum_q));

endmodule

// File: rtl/wu_phase_fsm.sv
module wu_phase_fsm
    import wu_pkg::*;
#(
    parameter int unsigned PIPE_LEN = 4000,
    parameter int unsigned MEAS_LEN = 1000000,
    parameter int unsigned MEAS_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_i,
    input  logic              retire_i,
    input  logic              cold_i,
    input  logic              zero_lines_i,
    input  logic              win_fire_i,
    output logic [1:0]        phase_o,
    output logic              warm_o,
    output logic              func_o,
    output logic [MEAS_W-1:0] meas_cnt_o
);
    localparam int unsigned CMAX = (PIPE_LEN > MEAS_LEN) ? PIPE_LEN : MEAS_LEN;
    localparam int unsigned CW   = (CMAX > 2) ? $clog2(CMAX) : 1;

    wu_phase_e         state_q, state_d;
    logic [CW-1:0]     cnt_q;
    logic [MEAS_W-1:0] meas_q;
    logic              count_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (begin_i) begin
            state_d = PH_FUNC;
        end else begin
            unique case (state_q)
                PH_FUNC: if (zero_lines_i || win_fire_i) state_d = PH_PIPE;
                PH_PIPE: if (retire_i && (cnt_q == CW'(PIPE_LEN - 1))) state_d = PH_MEAS;
                PH_MEAS: if (retire_i && (cnt_q == CW'(MEAS_LEN - 1))) state_d = PH_DONE;
                PH_DONE: state_d = PH_DONE;
                default: state_d = PH_FUNC;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_FUNC;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        phase_o    = state_q;
        warm_o     = (state_q != PH_FUNC);
        func_o     = (state_q == PH_FUNC);
        count_en   = (state_q == PH_PIPE) || (state_q == PH_MEAS);
        meas_cnt_o = meas_q;
    end

    // phase length and measurement counters
    always_ff @(posedge clk) begin
        if (!rst_n || begin_i) begin
            cnt_q  <= '0;
            meas_q <= '0;
        end else begin
            if (state_q != state_d) begin
                cnt_q <= '0;
            end else if (retire_i && count_en) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (count_en && cold_i && (meas_q != {MEAS_W{1'b1}})) begin
                meas_q <= meas_q + 1'b1;
            end
        end
    end

    // R8: finished stays finished until begin
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_DONE && !begin_i) |=> (state_q == PH_DONE));

    // R10: begin restarts functional warm-up with an empty total
    p_begin_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        begin_i |=> (state_q == PH_FUNC) && (meas_q == '0));

    // R6: no cold lines left ends functional warm-up at the next edge
    p_zero_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_FUNC && !begin_i && zero_lines_i) |=> (state_q == PH_PIPE));

    // R9: the total is frozen outside the pipeline and measured phases
    p_total_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PH_FUNC || state_q == PH_DONE) && !begin_i) |=> $stable(meas_q));

    // R7: pipeline warm-up can only hold or advance to measurement
    p_pipe_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_PIPE && !begin_i) |=> (state_q == PH_PIPE || state_q == PH_MEAS));

endmodule

// File: rtl/wu_detector.sv
module wu_detector
    import wu_pkg::*;
#(
    parameter int unsigned INTERVAL_LEN = 10000,
    parameter int unsigned HIST_N       = 20,
    parameter int unsigned THRESH_T     = 10,
    parameter int unsigned ACC_W        = 16,
    parameter int unsigned PIPE_LEN     = 4000,
    parameter int unsigned MEAS_LEN     = 1000000,
    parameter int unsigned MEAS_W       = 20,
    parameter int unsigned LINE_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              begin_i,
    input  logic              retire_i,
    input  logic              cold_acc_i,
    input  logic [LINE_W-1:0] cold_lines_i,
    output logic [1:0]        phase_o,
    output logic              warm_o,
    output logic [MEAS_W-1:0] meas_cold_o
);
    logic             func_w;
    logic             iv_done_w;
    logic [ACC_W-1:0] iv_count_w;
    logic             fire_w;
    logic             zero_lines_w;

    assign zero_lines_w = (cold_lines_i == '0);

    wu_interval_ctr #(
        .INTERVAL_LEN (INTERVAL_LEN),
        .ACC_W        (ACC_W)
    ) u_ivl (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (begin_i),
        .active_i (func_w),
        .retire_i (retire_i),
        .cold_i   (cold_acc_i),
        .done_o   (iv_done_w),
        .count_o  (iv_count_w)
    );

    wu_window #(
        .HIST_N   (HIST_N),
        .THRESH_T (THRESH_T),
        .ACC_W    (ACC_W)
    ) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (begin_i),
        .push_i (iv_done_w),
        .val_i  (iv_count_w),
        .fire_o (fire_w)
    );

    wu_phase_fsm #(
        .PIPE_LEN (PIPE_LEN),
        .MEAS_LEN (MEAS_LEN),
        .MEAS_W   (MEAS_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .begin_i      (begin_i),
        .retire_i     (retire_i),
        .cold_i       (cold_acc_i),
        .zero_lines_i (zero_lines_w),
        .win_fire_i   (fire_w),
        .phase_o      (phase_o),
        .warm_o       (warm_o),
        .func_o       (func_w),
        .meas_cnt_o   (meas_cold_o)
    );

    // R4: a window pass only ever arrives while functional warm-up runs or just after
    p_fire_in_func_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_w && func_w && !begin_i) |=> (phase_o == 2'b01));

endmodule

// File: tb/wu_detector_tb_top.sv
`timescale 1ns/1ps
module wu_detector_tb_top;

    localparam int unsigned IL  = 8;
    localparam int unsigned HN  = 4;
    localparam int unsigned TT  = 2;
    localparam int unsigned PL  = 5;
    localparam int unsigned ML  = 12;
    localparam int unsigned MW  = 4;
    localparam int unsigned LW  = 8;
    localparam int          NV  = 15;

    // columns: begin before interval, cold flags in interval, expected phase after
    localparam int VEC [NV][3] = '{
        '{1, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, '{0, 0, 1},
        '{1, 3, 0}, '{0, 3, 0}, '{0, 3, 0}, '{0, 3, 0}, '{0, 0, 0}, '{0, 0, 1},
        '{1, 2, 0}, '{0, 2, 0}, '{0, 2, 0}, '{0, 2, 0}, '{0, 1, 1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          begin_s = 1'b0;
    logic          retire_s = 1'b0;
    logic          cold_s = 1'b0;
    logic [LW-1:0] lines_s = 8'd100;
    logic [1:0]    phase_w;
    logic          warm_w;
    logic [MW-1:0] meas_w;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    wu_detector #(
        .INTERVAL_LEN (IL), .HIST_N (HN), .THRESH_T (TT), .ACC_W (8),
        .PIPE_LEN (PL), .MEAS_LEN (ML), .MEAS_W (MW), .LINE_W (LW)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .begin_i      (begin_s),
        .retire_i     (retire_s),
        .cold_acc_i   (cold_s),
        .cold_lines_i (lines_s),
        .phase_o      (phase_w),
        .warm_o       (warm_w),
        .meas_cold_o  (meas_w)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic c);
        @(negedge clk);
        retire_s = r;
        cold_s   = c;
        begin_s  = 1'b0;
    endtask

    task automatic idle();
        step(1'b0, 1'b0);
    endtask

    task automatic do_begin();
        @(negedge clk);
        retire_s = 1'b0;
        cold_s   = 1'b0;
        begin_s  = 1'b1;
        idle();
    endtask

    task automatic run_interval(input int c);
        for (int i = 0; i < int'(IL); i++) begin
            step(1'b1, i < c);
        end
        idle();
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state, R11 warm low in phase 00
        chk("R1 phase after reset", phase_w, 0);
        chk("R1 total after reset", meas_w, 0);
        chk("R11 warm after reset", warm_w, 0);

        // vector table: R2 interval counts, R3 fill, R4 threshold edge, R5 sliding, R10 clear
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][0] != 0) do_begin();
            run_interval(VEC[v][1]);
            chk($sformatf("R3 R4 R5 R2 vector %0d phase", v), phase_w, VEC[v][2]);
            chk($sformatf("R11 vector %0d warm", v), warm_w, VEC[v][2]);
        end

        // R6 early exit mid-run
        do_begin();
        run_interval(2);
        chk("R6 before zero lines", phase_w, 0);
        @(negedge clk);
        lines_s = '0;
        idle();
        chk("R6 zero lines exit", phase_w, 1);
        lines_s = 8'd100;

        // R7 pipeline length, R9 counting in PIPE
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        idle();
        chk("R7 still PIPE after PIPE_LEN-1", phase_w, 1);
        chk("R9 total in PIPE", meas_w, 2);
        step(1'b1, 1'b0);
        idle();
        chk("R7 MEAS after PIPE_LEN", phase_w, 2);

        // R8 measured length, R9 counting in MEAS
        for (int i = 0; i < int'(ML) - 1; i++) begin
            step(1'b1, i < 3);
        end
        idle();
        chk("R8 still MEAS after MEAS_LEN-1", phase_w, 2);
        chk("R9 total in MEAS", meas_w, 5);
        step(1'b1, 1'b0);
        idle();
        chk("R8 DONE after MEAS_LEN", phase_w, 3);

        // R8 sticky DONE, R9 frozen in DONE
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b1);
        end
        idle();
        chk("R8 DONE holds", phase_w, 3);
        chk("R9 total frozen in DONE", meas_w, 5);
        chk("R11 warm in DONE", warm_w, 1);

        // R10 begin from DONE
        do_begin();
        chk("R10 phase after begin", phase_w, 0);
        chk("R10 total after begin", meas_w, 0);
        chk("R11 warm after begin", warm_w, 0);

        // R9 no counting in FUNC
        run_interval(5);
        chk("R9 total unchanged in FUNC", meas_w, 0);

        // R9 saturation in PIPE
        @(negedge clk);
        lines_s = '0;
        idle();
        lines_s = 8'd100;
        chk("R6 exit for saturation test", phase_w, 1);
        for (int i = 0; i < 20; i++) begin
            step(1'b0, 1'b1);
        end
        idle();
        chk("R9 total saturates", meas_w, 15);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule